// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is a single output cell of a sum-of-products logic fabric. It receives the OR-sum of its product terms and can either pass that sum straight to its pad or hold it in a storage flop. The flop loads on a rising edge of one of two capture-clock inputs, and a configuration bit picks which one. The pad level can be inverted. The pad enable comes from a per-cell product term. A feedback signal returns to the logic array, taken either from the flop or from the pin. Fabric-wide terms can clear the flop at once or set it on the next capture edge. A test preload copies the pin level straight into the flop, so that arbitrary states can be forced.

The cell runs on one system clock, `clk`. The two capture clocks arrive as level inputs that are sampled on `clk`. A rising edge is detected when an input reads 1 at a `clk` edge after it read 0 at the previous edge, and the flop updates at that same `clk` edge. The four configuration bits sit in a small register, loaded through `cfg_we`/`cfg_wdata`. Their reset value is the unprogrammed pattern 4'b1111.

Top module: `mcell_top`

## Requirements
- R1: After reset the configuration is 4'b1111 and the flop holds 0. The pad therefore shows the live sum in the unprogrammed setting. An active-low registered setting shows 1 at the pad before any capture.
- R2: With configuration bit 1 = 1 the pad follows `sum_in` combinationally. With bit 1 = 0 it follows the flop.
- R3: Configuration bit 0 = 1 drives the selected level to `pad_out` unchanged. Bit 0 = 0 inverts it. This applies in both registered and combinational settings.
- R4: With configuration bit 2 = 1 the flop captures `sum_in` on a rising edge of `cap_clk1`. With bit 2 = 0 it captures on a rising edge of `cap_clk2`. Edges on the unselected input leave the flop unchanged.
- R5: Feedback comes from the flop when configuration bits 1 and 3 differ, and from `pad_in` when they are equal. The flop value is fed back uninverted.
- R6: `ar_term` = 1 forces the flop value seen by the pad and the feedback to 0 in the same cycle, without a clock. On the next `clk` edge it clears the flop. It wins over a preset edge and over preload.
- R7: `sp_term` = 1 at a selected capture edge loads 1 into the flop instead of `sum_in`.
- R8: `preload` = 1 loads `pad_in` into the flop at the next `clk` edge, with no capture edge needed. Preload takes priority over a capture edge.
- R9: `pad_oe` equals `oe_term`. With the driver off and pin feedback selected, `fb_out` follows `pad_in`.
- R10: `cfg_we` = 1 loads `cfg_wdata` at the next `clk` edge. The bit mapping is bit 0 polarity, bit 1 bypass, bit 2 clock pick, bit 3 feedback default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_wdata | input | 4 | Configuration bits {fb default, clock pick, bypass, polarity} |
| sum_in | input | 1 | OR-sum of the cell's product terms |
| cap_clk1 | input | 1 | Capture clock input 1, sampled |
| cap_clk2 | input | 1 | Capture clock input 2, sampled |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous set term |
| oe_term | input | 1 | Per-cell pad driver enable term |
| preload | input | 1 | Test preload strobe, loads the flop from the pin |
| pad_in | input | 1 | Level present on the pin |
| pad_out | output | 1 | Data driven towards the pin |
| pad_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback to the logic array |

## Verification
The clear term and the set term can fall in the same cycle as a selected capture edge. The bench holds `ar_term` and `sp_term` high together across a rising `cap_clk1` sample, with the flop previously set to 1. It then requires 0 at the pad both during the overlap and after `ar_term` drops. The same overlap is provoked between clear and preload with a pin level of 1, and it is judged the same way at the pad.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    // Packed MSB first so that bit [3:0] of cfg_wdata maps directly.
    typedef struct packed {
        logic fb_dflt;   // bit 3: 1 = default feedback choice, 0 = swapped
        logic clk_pick;  // bit 2: 1 = capture clock 1, 0 = capture clock 2
        logic bypass;    // bit 1: 1 = combinational, 0 = registered
        logic pol_high;  // bit 0: 1 = true level at pad, 0 = inverted
    } mcell_cfg_t;

    typedef struct packed {
        mcell_cfg_t cfg;
        logic       store;
    } mcell_state_t;

    localparam int CFG_BITS = $bits(mcell_cfg_t);

endpackage

// File: rtl/mcell_edge.sv
module mcell_edge #(
    parameter int NCLK = 2,
    localparam int SELW = (NCLK > 1) ? $clog2(NCLK) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLK-1:0] clk_in,
    input  logic [SELW-1:0] pick,
    output logic            rise_sel
);

    logic [NCLK-1:0] prev_d, prev_q;
    logic [NCLK-1:0] rise;

    // One previous-sample flop per input, so switching the pick never
    // fabricates an edge.
    genvar gi;
    generate
        for (gi = 0; gi < NCLK; gi++) begin : g_det
            assign rise[gi] = clk_in[gi] & ~prev_q[gi];
        end
    endgenerate

    always_comb begin
        prev_d = clk_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise_sel = rise[pick];

endmodule

// File: rtl/mcell_core.sv
module mcell_core
    import mcell_pkg::*;
#(
    parameter mcell_cfg_t RESET_CFG = 4'b1111
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_BITS-1:0] cfg_wdata,
    input  logic                rise_sel,
    input  logic                sum_in,
    input  logic                sp_term,
    input  logic                ar_term,
    input  logic                preload,
    input  logic                pad_in,
    output mcell_cfg_t          cfg_o,
    output logic                store_o,
    output logic                store_vis
);

    mcell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.cfg = mcell_cfg_t'(cfg_wdata);
        // Priority: clear, then preload, then a capture edge.
        if (ar_term)       st_d.store = 1'b0;
        else if (preload)  st_d.store = pad_in;
        else if (rise_sel) st_d.store = sp_term ? 1'b1 : sum_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: RESET_CFG, store: 1'b0};
        else        st_q <= st_d;
    end

    assign cfg_o     = st_q.cfg;
    assign store_o   = st_q.store;
    // The clear acts without waiting for a clock.
    assign store_vis = ar_term ? 1'b0 : st_q.store;

endmodule

// File: rtl/mcell_route.sv
module mcell_route
    import mcell_pkg::*;
(
    input  mcell_cfg_t cfg,
    input  logic       sum_in,
    input  logic       store_vis,
    input  logic       pad_in,
    input  logic       oe_term,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       fb_out
);

    logic lvl;
    logic fb_from_store;

    always_comb begin
        lvl           = cfg.bypass ? sum_in : store_vis;
        pad_out       = cfg.pol_high ? lvl : ~lvl;
        fb_from_store = cfg.bypass ^ cfg.fb_dflt;
        fb_out        = fb_from_store ? store_vis : pad_in;
        pad_oe        = oe_term;
    end

endmodule

// File: rtl/mcell_top.sv
module mcell_top
    import mcell_pkg::*;
#(
    parameter int         NCLK      = 2,
    parameter mcell_cfg_t RESET_CFG = 4'b1111
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_BITS-1:0] cfg_wdata,
    input  logic                sum_in,
    input  logic                cap_clk1,
    input  logic                cap_clk2,
    input  logic                ar_term,
    input  logic                sp_term,
    input  logic                oe_term,
    input  logic                preload,
    input  logic                pad_in,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                fb_out
);

    localparam int SELW = (NCLK > 1) ? $clog2(NCLK) : 1;

    mcell_cfg_t      cfg_q;
    logic            store_q;
    logic            store_vis;
    logic            sel_rise;
    logic [NCLK-1:0] clk_vec;
    logic [SELW-1:0] pick;

    assign clk_vec = {cap_clk2, cap_clk1};
    // clk_pick = 1 selects clock 1 (index 0).
    assign pick = SELW'(~cfg_q.clk_pick);

    mcell_edge #(.NCLK(NCLK)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_in   (clk_vec),
        .pick     (pick),
        .rise_sel (sel_rise)
    );

    mcell_core #(.RESET_CFG(RESET_CFG)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .rise_sel  (sel_rise),
        .sum_in    (sum_in),
        .sp_term   (sp_term),
        .ar_term   (ar_term),
        .preload   (preload),
        .pad_in    (pad_in),
        .cfg_o     (cfg_q),
        .store_o   (store_q),
        .store_vis (store_vis)
    );

    mcell_route u_route (
        .cfg       (cfg_q),
        .sum_in    (sum_in),
        .store_vis (store_vis),
        .pad_in    (pad_in),
        .oe_term   (oe_term),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .fb_out    (fb_out)
    );

endmodule

// File: rtl/mcell_chk.sv
module mcell_chk
    import mcell_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic [CFG_BITS-1:0] cfg_wdata,
    input logic                ar_term,
    input logic                sp_term,
    input logic                preload,
    input logic                pad_in,
    input logic                pad_out,
    input logic                sel_rise,
    input logic                store_q,
    input mcell_cfg_t          cfg_q
);

    // R6: clear shows at the pad without a clock edge
    a_r6_clear_at_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_term && !cfg_q.bypass) |-> (pad_out == !cfg_q.pol_high));

    // R6: clear empties the flop on the following edge
    a_r6_clear_flop: assert property (@(posedge clk) disable iff (!rst_n)
        ar_term |=> (store_q == 1'b0));

    // R8: preload copies the pin level
    a_r8_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (preload && !ar_term) |=> (store_q == $past(pad_in)));

    // R7: set term at a selected edge loads 1
    a_r7_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rise && sp_term && !ar_term && !preload) |=> store_q);

    // R4: without a selected edge the flop holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_rise && !preload && !ar_term) |=> $stable(store_q));

    // R10: configuration load
    a_r10_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == mcell_cfg_t'($past(cfg_wdata))));

endmodule

bind mcell_top mcell_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .ar_term   (ar_term),
    .sp_term   (sp_term),
    .preload   (preload),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .sel_rise  (sel_rise),
    .store_q   (store_q),
    .cfg_q     (cfg_q)
);

// File: tb/mcell_top_test.sv
module mcell_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // {cfg[3:0], sum, pin, exp_pad, exp_fb}; flop is 0 throughout.
    localparam logic [7:0] VEC [NVEC] = '{
        {4'b1111, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'b1111, 1'b0, 1'b1, 1'b0, 1'b1},
        {4'b1110, 1'b1, 1'b1, 1'b0, 1'b1},
        {4'b1110, 1'b0, 1'b0, 1'b1, 1'b0},
        {4'b0111, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'b0110, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'b1101, 1'b1, 1'b1, 1'b0, 1'b0},
        {4'b1100, 1'b1, 1'b1, 1'b1, 1'b0},
        {4'b0101, 1'b0, 1'b1, 1'b0, 1'b1},
        {4'b0100, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [3:0] cfg_wdata;
    logic       sum_in, cap_clk1, cap_clk2;
    logic       ar_term, sp_term, oe_term, preload, pad_in;
    logic       pad_out, pad_oe, fb_out;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mcell_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .sum_in    (sum_in),
        .cap_clk1  (cap_clk1),
        .cap_clk2  (cap_clk2),
        .ar_term   (ar_term),
        .sp_term   (sp_term),
        .oe_term   (oe_term),
        .preload   (preload),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .fb_out    (fb_out)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wcfg(input logic [3:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we    = 1'b0;
    endtask

    task automatic pulse(input bit use_two);
        if (use_two) cap_clk2 = 1'b1;
        else         cap_clk1 = 1'b1;
        tick();
        cap_clk1 = 1'b0;
        cap_clk2 = 1'b0;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; sum_in = 1'b0;
        cap_clk1 = 1'b0; cap_clk2 = 1'b0; ar_term = 1'b0; sp_term = 1'b0;
        oe_term = 1'b0; preload = 1'b0; pad_in = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1: unprogrammed config is combinational, active high, pin feedback
        sum_in = 1'b1; #1;
        chk("R1 reset pad follows sum", pad_out, 1'b1);
        chk("R1 reset pin feedback", fb_out, 1'b0);
        chk("R9 reset driver off", pad_oe, 1'b0);
        // R1: active-low registered, flop still 0, pad shows 1
        wcfg(4'b1100); sum_in = 1'b0; #1;
        chk("R1 active-low registered at power-up", pad_out, 1'b1);

        // Table: R2 R3 R5 R10 with the flop at 0
        for (int i = 0; i < NVEC; i++) begin
            wcfg(VEC[i][7:4]);
            sum_in = VEC[i][3];
            pad_in = VEC[i][2];
            #1;
            chk($sformatf("R2/R3 vec %0d pad", i), pad_out, VEC[i][1]);
            chk($sformatf("R5/R10 vec %0d fb", i), fb_out, VEC[i][0]);
        end
        pad_in = 1'b0;

        // R4: clock pick
        wcfg(4'b1101); sum_in = 1'b1;
        pulse(1'b1); #1;
        chk("R4 unselected clock 2 ignored", pad_out, 1'b0);
        pulse(1'b0); #1;
        chk("R4 clock 1 capture", pad_out, 1'b1);
        wcfg(4'b1001); sum_in = 1'b0;
        pulse(1'b0); #1;
        chk("R4 unselected clock 1 ignored", pad_out, 1'b1);
        pulse(1'b1); #1;
        chk("R4 clock 2 capture", pad_out, 1'b0);
        chk("R5 registered default store feedback", fb_out, 1'b0);

        // R7: preset on edge
        wcfg(4'b1101); sum_in = 1'b0; sp_term = 1'b1;
        pulse(1'b0); sp_term = 1'b0; #1;
        chk("R7 preset loads 1", pad_out, 1'b1);
        chk("R5 store feedback after preset", fb_out, 1'b1);

        // R6: clear immediate and against simultaneous preset edge
        sum_in = 1'b1; ar_term = 1'b1; #1;
        chk("R6 clear immediate at pad", pad_out, 1'b0);
        chk("R6 clear immediate at feedback", fb_out, 1'b0);
        sp_term = 1'b1; cap_clk1 = 1'b1;
        tick(); #1;
        chk("R6 clear beats preset during overlap", pad_out, 1'b0);
        ar_term = 1'b0; sp_term = 1'b0; cap_clk1 = 1'b0; #1;
        chk("R6 flop cleared after overlap", pad_out, 1'b0);
        tick();

        // R8: preload
        preload = 1'b1; pad_in = 1'b1;
        tick(); preload = 1'b0; #1;
        chk("R8 preload 1", pad_out, 1'b1);
        preload = 1'b1; pad_in = 1'b0;
        tick(); preload = 1'b0; #1;
        chk("R8 preload 0", pad_out, 1'b0);
        preload = 1'b1; pad_in = 1'b1; ar_term = 1'b1;
        tick(); preload = 1'b0; ar_term = 1'b0; #1;
        chk("R6 clear beats preload", pad_out, 1'b0);

        // R9: driver enable and pin as input
        oe_term = 1'b1; #1;
        chk("R9 driver on", pad_oe, 1'b1);
        wcfg(4'b1111); oe_term = 1'b0; pad_in = 1'b1; #1;
        chk("R9 driver off", pad_oe, 1'b0);
        chk("R9 pin input feedback high", fb_out, 1'b1);
        pad_in = 1'b0; #1;
        chk("R9 pin input feedback low", fb_out, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule